// File: doc/BRIEF.md
# Linear Flash Read Cache

This block answers memory-mapped reads of a serial flash window from one 1 KB line buffer. A read whose whole 32-bit word falls inside the buffered line is answered directly. A read that falls outside the line stalls. The block then works out the flash address and the upper-device select for that line, and asks an external flash read engine to refill the buffer byte by byte. When the refill is acknowledged the read is retried and answered.

The flash address is the bus address rounded down to a 1 KB boundary and divided by the number of active devices. When two devices run side by side, each one holds half of every line. Each device spans 16 MB. Any set bit above bit 23 of the flash address drives the upper-device select. A strobe marks every write to the linear configuration register, and each such strobe discards the buffered line.

Top module: `lin_flash_rdcache`

## Requirements
- R1: After reset the line is invalid, and `fill_req`, `rd_valid` and `upper_page` are all low.
- R2: A hit accepted on a clock edge raises `rd_valid` for exactly one cycle after that edge. `rd_data` is then little-endian: byte k of the word is the line byte at offset (address - base + k).
- R3: A read hits only when the line is valid and the address lies from the line base through base + 1020. Any other read raises `fill_req`.
- R4: `fill_addr` equals the read address with its low 10 bits cleared, divided by 2 when `par_en` is 1 and unchanged when it is 0. The stored line base is that value multiplied back by the same factor.
- R5: On every refill, `upper_page` is updated to the OR of `fill_addr` bits 24 and above.
- R6: `fill_req` and `fill_addr` hold until `fill_ack`, and `rd_valid` stays low for the whole refill. The stalled read is answered one cycle after the acknowledge cycle.
- R7: A `cfg_wr` pulse invalidates the line, so the next read to the same line refills it again.
- R8: `rd_size` 0 returns only byte 0 of the word, 1 returns bytes 0 and 1, and 2 or 3 returns all four bytes. Unreturned bits read as zero.
- R9: A read at line offset 1021 to 1023 refills even when its line is valid, and is then answered once. Bytes past the line end read as zero.
- R10: While `fill_we` is high, `fill_byte` is stored at line offset `fill_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read request, held until `rd_valid` |
| rd_addr | input | ADDR_W | Read byte address |
| rd_size | input | 2 | 0 byte, 1 half word, 2/3 word |
| rd_valid | output | 1 | One-cycle response strobe |
| rd_data | output | 32 | Response data |
| par_en | input | 1 | Two devices in parallel |
| cfg_wr | input | 1 | Write to the linear configuration register |
| fill_req | output | 1 | Refill request |
| fill_addr | output | ADDR_W | Flash address of the line to load |
| upper_page | output | 1 | Upper-device select |
| fill_we | input | 1 | Refill byte write enable |
| fill_idx | input | 10 | Refill byte offset in the line |
| fill_byte | input | 8 | Refill byte |
| fill_ack | input | 1 | Refill complete |

## Verification
A hit has a latency of one edge: the bench drives `rd_req` on a falling edge and expects `rd_valid` at the next falling edge. A miss shows `fill_req`, `fill_addr` and `upper_page` one edge after the request, and the bench samples them on that falling edge. The stub then streams the line and acknowledges it. The answer is due one cycle after the acknowledge cycle. The bench samples every output on falling edges, and it counts any `rd_valid` seen while the refill is in progress as a stall failure.

// File: rtl/lfrc_pkg.sv
package lfrc_pkg;
  typedef enum logic {ST_IDLE, ST_FILL} lfrc_state_e;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/lfrc_line_tag.sv
module lfrc_line_tag #(
  parameter int ADDR_W = 26,
  parameter int LINE_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load_base,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              set_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              tag_valid,
  output logic              hit
);
  logic [ADDR_W-1:0] base_q;

  function automatic logic in_window(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    logic [ADDR_W:0] top;
    top = {1'b0, b} + (ADDR_W+1)'(LINE_BYTES - 4);
    return ({1'b0, a} >= {1'b0, b}) && ({1'b0, a} <= top);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_valid <= 1'b0;
      base_q    <= '1;
    end else begin
      if (load_base) begin
        base_q    <= base_in;
        tag_valid <= 1'b0;
      end
      if (clr) tag_valid <= 1'b0;
      else if (set_valid) tag_valid <= 1'b1;
    end
  end

  assign hit = tag_valid && in_window(rd_addr, base_q);

  // R7
  cfg_invalidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tag_valid);
  // R3
  refill_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_base |=> !hit);
endmodule

// File: rtl/lfrc_line_buf.sv
module lfrc_line_buf #(
  parameter int LINE_BYTES = 1024,
  localparam int LG = $clog2(LINE_BYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [LG-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [LG-1:0] off,
  output logic [31:0]   word
);
  logic [7:0] mem [LINE_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [LG:0] pos;
    assign pos = {1'b0, off} + (LG+1)'(k);
    assign word[8*k +: 8] = pos[LG] ? 8'h00 : mem[pos[LG-1:0]];
  end
endmodule

// File: rtl/lin_flash_rdcache.sv
module lin_flash_rdcache #(
  parameter int ADDR_W = 26,
  parameter int LINE_BYTES = 1024,
  parameter int PAGE_BIT = 24,
  localparam int LG = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_size,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              par_en,
  input  logic              cfg_wr,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              upper_page,
  input  logic              fill_we,
  input  logic [LG-1:0]     fill_idx,
  input  logic [7:0]        fill_byte,
  input  logic              fill_ack
);
  import lfrc_pkg::*;

  function automatic logic [ADDR_W-1:0] flash_of(input logic [ADDR_W-1:0] a, input logic par);
    logic [ADDR_W-1:0] al;
    al = a & ~ADDR_W'(LINE_BYTES - 1);
    return par ? (al >> 1) : al;
  endfunction

  function automatic logic [ADDR_W-1:0] base_of(input logic [ADDR_W-1:0] f, input logic par);
    return par ? (f << 1) : f;
  endfunction

  function automatic logic upper_of(input logic [ADDR_W-1:0] f);
    return |(f >> PAGE_BIT);
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00ff;
      SZ_HALF: return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  lfrc_state_e       state;
  logic              force_serve, kill;
  logic              hit, tag_valid;
  logic [31:0]       word;
  logic [ADDR_W-1:0] flash_now;

  // named events
  logic accept_evt, serve_evt, miss_evt, fill_done;
  assign flash_now  = flash_of(rd_addr, par_en);
  assign accept_evt = (state == ST_IDLE) && rd_req && !rd_valid;
  assign serve_evt  = accept_evt && (hit || force_serve);
  assign miss_evt   = accept_evt && !(hit || force_serve);
  assign fill_done  = (state == ST_FILL) && fill_ack;

  lfrc_line_tag #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_tag (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .load_base(miss_evt),
    .base_in(base_of(flash_now, par_en)),
    .set_valid(fill_done && !kill), .rd_addr(rd_addr),
    .tag_valid(tag_valid), .hit(hit)
  );

  lfrc_line_buf #(.LINE_BYTES(LINE_BYTES)) u_buf (
    .clk(clk), .we(fill_we), .widx(fill_idx), .wdata(fill_byte),
    .off(rd_addr[LG-1:0]), .word(word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      fill_req    <= 1'b0;
      fill_addr   <= '0;
      upper_page  <= 1'b0;
      force_serve <= 1'b0;
      kill        <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (serve_evt) begin
        rd_valid    <= 1'b1;
        rd_data     <= word & size_mask(rd_size);
        force_serve <= 1'b0;
      end
      if (miss_evt) begin
        state      <= ST_FILL;
        fill_req   <= 1'b1;
        fill_addr  <= flash_now;
        upper_page <= upper_of(flash_now);
        kill       <= 1'b0;
      end
      if (state == ST_FILL) begin
        if (cfg_wr) kill <= 1'b1;
        if (fill_ack) begin
          state       <= ST_IDLE;
          fill_req    <= 1'b0;
          force_serve <= !(kill || cfg_wr);
        end
      end
    end
  end

  // R6
  fill_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_ack |=> fill_req && $stable(fill_addr));
  // R6
  no_resp_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !rd_valid);
  // R2
  single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R5
  upper_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_req) |-> upper_page == |(fill_addr >> PAGE_BIT));
  // R8
  byte_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serve_evt && rd_size == SZ_BYTE |=> rd_data[31:8] == 24'd0);
endmodule

// File: tb/lin_flash_rdcache_tb.sv
`timescale 1ns/1ps
module lin_flash_rdcache_tb;
  localparam int AW = 26;
  logic clk = 0, rst_n = 0;
  logic rd_req = 0; logic [AW-1:0] rd_addr = '0; logic [1:0] rd_size = 0;
  logic rd_valid; logic [31:0] rd_data;
  logic par_en = 0, cfg_wr = 0;
  logic fill_req, upper_page; logic [AW-1:0] fill_addr;
  logic fill_we = 0, fill_ack = 0; logic [9:0] fill_idx = 0; logic [7:0] fill_byte = 0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  lin_flash_rdcache u_dut (.clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_size(rd_size), .rd_valid(rd_valid), .rd_data(rd_data), .par_en(par_en),
    .cfg_wr(cfg_wr), .fill_req(fill_req), .fill_addr(fill_addr), .upper_page(upper_page),
    .fill_we(fill_we), .fill_idx(fill_idx), .fill_byte(fill_byte), .fill_ack(fill_ack));

  // addr, size, par, expect refill
  typedef struct packed { logic [31:0] a; logic [1:0] sz; logic par; logic fl; } vec_t;
  localparam vec_t VT [10] = '{
    '{32'h0000400, 2'd2, 1'b0, 1'b1}, '{32'h0000404, 2'd2, 1'b0, 1'b0},
    '{32'h00007FC, 2'd2, 1'b0, 1'b0}, '{32'h0000401, 2'd0, 1'b0, 1'b0},
    '{32'h0000402, 2'd1, 1'b0, 1'b0}, '{32'h0000800, 2'd3, 1'b0, 1'b1},
    '{32'h00003FC, 2'd2, 1'b0, 1'b1}, '{32'h10000C0, 2'd2, 1'b0, 1'b1},
    '{32'h10000C4, 2'd1, 1'b0, 1'b0}, '{32'h0000010, 2'd2, 1'b0, 1'b1}};

  function automatic logic [7:0] pat(int fa, int i);
    return 8'((i * 5) ^ ((i >> 8) * 17) ^ ((fa >> 10) * 29) ^ ((fa >> 24) * 3));
  endfunction

  function automatic int fa_of(int a, bit par);
    return (a & ~1023) / (par ? 2 : 1);
  endfunction

  function automatic logic [31:0] exp_word(int a, bit par, logic [1:0] sz);
    logic [31:0] w; int o;
    o = a & 1023;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = (o + k <= 1023) ? pat(fa_of(a, par), o + k) : 8'h00;
    if (sz == 0) w &= 32'hff; else if (sz == 1) w &= 32'hffff;
    return w;
  endfunction

  task automatic chk(bit ok, string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s act=%0h exp=%0h", r, act, exp); end
  endtask

  task automatic do_read(int a, logic [1:0] sz, bit par, bit exp_fill, string r);
    bit filled = 0, got = 0; int stall_bad = 0; int fa;
    fa = fa_of(a, par);
    par_en = par; rd_addr = AW'(a); rd_size = sz; rd_req = 1;
    for (int t = 0; t < 3000 && !got; t++) begin
      @(negedge clk);
      if (rd_valid) begin
        got = 1;
        chk(rd_data == exp_word(a, par, sz), r, rd_data, exp_word(a, par, sz));
      end else if (fill_req && !filled) begin
        filled = 1;
        // R4 R5
        chk(fill_addr == AW'(fa), "R4", fill_addr, fa);
        chk(upper_page == ((fa >> 24) != 0), "R5", upper_page, (fa >> 24) != 0);
        for (int i = 0; i < 1024; i++) begin
          fill_we = 1; fill_idx = 10'(i); fill_byte = pat(fa, i);
          @(negedge clk);
          if (rd_valid || !fill_req) stall_bad++;
        end
        fill_we = 0; fill_ack = 1;
        @(negedge clk);
        fill_ack = 0;
        // R6: response one cycle after the acknowledge cycle
        chk(stall_bad == 0 && !fill_req, "R6", stall_bad, 0);
      end
    end
    rd_req = 0;
    chk(got, {r, " no response"}, got, 1);
    // R3 refill expectation
    chk(filled == exp_fill, {r, " R3 refill"}, filled, exp_fill);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #35;
    // R1
    chk(!fill_req && !rd_valid && !upper_page, "R1 reset", {fill_req, rd_valid, upper_page}, 0);
    rst_n = 1;
    @(negedge clk);
    do_read(32'h0000040, 2'd2, 0, 1, "R1 first read refills");
    foreach (VT[i]) do_read(VT[i].a, VT[i].sz, VT[i].par, VT[i].fl,
      VT[i].sz < 2 ? "R8 R2" : "R2 R10");
    // R7
    @(negedge clk); cfg_wr = 1; @(negedge clk); cfg_wr = 0;
    do_read(32'h0000014, 2'd2, 0, 1, "R7");
    // R9: offset 1022 of valid line
    do_read(32'h00003FE, 2'd2, 0, 1, "R9");
    do_read(32'h00003FD, 2'd1, 0, 1, "R9 half");
    // R4 with two devices
    @(negedge clk); cfg_wr = 1; @(negedge clk); cfg_wr = 0;
    do_read(32'h0001800, 2'd2, 1, 1, "R4 par");
    do_read(32'h0001BFC, 2'd2, 1, 0, "R4 par hit");
    do_read(32'h2000808, 2'd2, 1, 1, "R5 par upper");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule